// File: doc/BRIEF.md
# Chaosnet Packet Header Validator

This block checks Chaosnet packets as they stream past, one 16-bit word per clock. Each word is read big-endian, so the first byte of a pair sits in bits 15:8. A start marker comes with the first word and a last marker with the final word. While the packet passes, the block copies the eight header words into output registers. It also keeps a running ones-complement sum over every word, and this sum includes the checksum word that the sender appends at the end.

One cycle after the final word, the block raises a single-cycle done strobe together with two verdicts. The first verdict is a bad-packet flag, set when the must-be-zero byte is nonzero or when the packet is too short to hold a full header. The second is a checksum-error flag, set when the whole packet does not fold to zero. The header fields and the verdicts keep their values until the next start marker.

Top module: `chaos_hdr_check`

## Requirements
- R1: After reset, every header field output, `pkt_done`, `bad_pkt` and `csum_err` read zero.
- R2: Packet word 0 holds the opcode in bits 15:8, which appears on `opcode`, and the must-be-zero byte in bits 7:0. If that byte is nonzero, `bad_pkt` is 1 at done.
- R3: Packet word 1 holds the forwarding count in bits 15:12, which appears on `fwd_count`, and the packet size in bits 11:0, which appears on `pkt_size`.
- R4: Packet words 2, 3, 4, 5, 6 and 7 appear on `dst_addr`, `dst_index`, `src_addr`, `src_index`, `pkt_number` and `ack_number` respectively.
- R5: The checksum is computed by adding all words of the packet, trailing checksum word included, in ones-complement form with the carry out of bit 15 added back in, and then inverting the result. `csum_err` is 0 at done exactly when this value is zero, and 1 otherwise.
- R6: A word is accepted on every clock in which `in_valid` is high. A new packet may start in the cycle directly after the previous packet's last word.
- R7: `pkt_done` is high for one cycle, in the cycle after the word marked last is accepted. `bad_pkt` and `csum_err` take their verdict values in that same cycle.
- R8: A packet of fewer than 8 words sets `bad_pkt`, and its header fields that received no word read zero.
- R9: Header fields and flags hold their values until the next accepted start word, which clears both flags and every field except the ones loaded from that start word.
- R10: Words presented while `in_valid` is low are ignored. Valid words that arrive without a start marker after a packet has ended are also ignored: they change no field and no flag, and they raise no done.
- R11: A start marker that arrives in the middle of a packet abandons the current packet and begins a new one.
- R12: Words after word 7 count toward the checksum only and leave the header fields unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Word qualifier |
| in_start | input | 1 | Marks the first word of a packet |
| in_last | input | 1 | Marks the final word of a packet |
| in_word | input | 16 | Packet word, first byte in bits 15:8 |
| opcode | output | 8 | Opcode byte |
| fwd_count | output | 4 | Forwarding count |
| pkt_size | output | 12 | Packet size field |
| dst_addr | output | 16 | Destination address |
| dst_index | output | 16 | Destination index |
| src_addr | output | 16 | Source address |
| src_index | output | 16 | Source index |
| pkt_number | output | 16 | Packet number |
| ack_number | output | 16 | Acknowledgement number |
| pkt_done | output | 1 | One-cycle end-of-packet strobe |
| bad_pkt | output | 1 | Must-be-zero violation or short packet |
| csum_err | output | 1 | Checksum did not fold to zero |

## Verification
The bench builds the block with the package defaults: 16-bit words and an 8-word header. With these values, a 1-word packet, a 4-word packet and packets of 10 or more words cover every position of the word counter, from the first word to saturation past the header. Payloads full of 0xFFFF words force the end-around carry on nearly every add. Back-to-back packets, gaps in the middle of a packet and restarts in the middle of a packet exercise the start and last handling.

// File: rtl/chx_pkg.sv
package chx_pkg;
    localparam int DATA_W    = 16;
    localparam int BYTE_W    = 8;
    localparam int HDR_WORDS = 8;
    localparam int IDX_W     = $clog2(HDR_WORDS + 1);

    typedef logic [DATA_W-1:0] word_t;

    // Decoded view of the captured header words
    typedef struct packed {
        logic [BYTE_W-1:0] opcode;
        logic [BYTE_W-1:0] mbz;
        logic [3:0]        fwd;
        logic [11:0]       size;
        word_t             dst_addr;
        word_t             dst_index;
        word_t             src_addr;
        word_t             src_index;
        word_t             pkt_number;
        word_t             ack_number;
    } hdr_t;

    typedef enum logic {
        SEQ_IDLE   = 1'b0,
        SEQ_ACTIVE = 1'b1
    } seq_state_e;

    // Ones-complement add: carry out of the top bit folds back in
    function automatic word_t oc_add(input word_t a, input word_t b);
        logic [DATA_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[DATA_W-1:0] + word_t'(s[DATA_W]);
    endfunction

    function automatic hdr_t decode_hdr(input logic [HDR_WORDS-1:0][DATA_W-1:0] w);
        hdr_t h;
        h.opcode     = w[0][DATA_W-1 -: BYTE_W];
        h.mbz        = w[0][BYTE_W-1:0];
        h.fwd        = w[1][15:12];
        h.size       = w[1][11:0];
        h.dst_addr   = w[2];
        h.dst_index  = w[3];
        h.src_addr   = w[4];
        h.src_index  = w[5];
        h.pkt_number = w[6];
        h.ack_number = w[7];
        return h;
    endfunction
endpackage

// File: rtl/chx_seq.sv
module chx_seq
    import chx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_start,
    input  logic             in_last,
    output logic             accept,
    output logic             first,
    output logic             final_w,
    output logic [IDX_W-1:0] idx,
    output logic             short_pkt
);
    seq_state_e       state_q;
    logic [IDX_W-1:0] idx_q;

    assign accept    = in_valid && (in_start || state_q == SEQ_ACTIVE);
    assign first     = accept && in_start;
    assign final_w   = accept && in_last;
    assign idx       = in_start ? '0 : idx_q;
    assign short_pkt = idx < IDX_W'(HDR_WORDS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            idx_q   <= '0;
        end else if (accept) begin
            state_q <= in_last ? SEQ_IDLE : SEQ_ACTIVE;
            idx_q   <= (idx == IDX_W'(HDR_WORDS)) ? idx : idx + 1'b1;
        end
    end

    // R10
    stray_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_start && state_q == SEQ_IDLE) |=> $stable(idx_q));

    // R12
    idx_bound_chk: assert property (@(posedge clk) disable iff (rst)
        idx_q <= IDX_W'(HDR_WORDS));

    // R11
    restart_idx_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_start && !in_last) |=> (idx_q == IDX_W'(1)));
endmodule

// File: rtl/chx_field_cap.sv
module chx_field_cap
    import chx_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              accept,
    input  logic                              first,
    input  logic [IDX_W-1:0]                  idx,
    input  word_t                             word,
    output logic [HDR_WORDS-1:0][DATA_W-1:0]  hw
);
    for (genvar k = 0; k < HDR_WORDS; k++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                hw[k] <= '0;
            end else if (accept && idx == IDX_W'(k)) begin
                hw[k] <= word;
            end else if (first) begin
                hw[k] <= '0;
            end
        end
    end

    // R9
    start_clears_chk: assert property (@(posedge clk) disable iff (rst)
        first |=> (hw[HDR_WORDS-1] == '0 && hw[1] == '0));

    // R10
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !accept |=> $stable(hw));
endmodule

// File: rtl/chx_csum_acc.sv
module chx_csum_acc
    import chx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  accept,
    input  logic  first,
    input  word_t word,
    output word_t sum_next
);
    word_t acc_q;

    assign sum_next = oc_add(first ? '0 : acc_q, word);

    always_ff @(posedge clk) begin
        if (rst)         acc_q <= '0;
        else if (accept) acc_q <= sum_next;
    end

    // R5
    seed_chk: assert property (@(posedge clk) disable iff (rst)
        first |=> (acc_q == $past(word)));
endmodule

// File: rtl/chx_verdict.sv
module chx_verdict
    import chx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  first,
    input  logic  final_w,
    input  logic  short_pkt,
    input  logic  mbz_nz,
    input  word_t sum_next,
    output logic  done,
    output logic  bad,
    output logic  err
);
    always_ff @(posedge clk) begin
        if (rst) begin
            done <= 1'b0;
            bad  <= 1'b0;
            err  <= 1'b0;
        end else begin
            done <= final_w;
            if (final_w) begin
                bad <= mbz_nz || short_pkt;
                err <= (~sum_next) != '0;
            end else if (first) begin
                bad <= 1'b0;
                err <= 1'b0;
            end
        end
    end

    // R7
    done_cause_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(final_w));

    // R9
    flags_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (first && !final_w) |=> (!bad && !err && !done));

    // R8
    short_bad_chk: assert property (@(posedge clk) disable iff (rst)
        (final_w && short_pkt) |=> bad);
endmodule

// File: rtl/chaos_hdr_check.sv
module chaos_hdr_check
    import chx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic        in_start,
    input  logic        in_last,
    input  logic [15:0] in_word,
    output logic [7:0]  opcode,
    output logic [3:0]  fwd_count,
    output logic [11:0] pkt_size,
    output logic [15:0] dst_addr,
    output logic [15:0] dst_index,
    output logic [15:0] src_addr,
    output logic [15:0] src_index,
    output logic [15:0] pkt_number,
    output logic [15:0] ack_number,
    output logic        pkt_done,
    output logic        bad_pkt,
    output logic        csum_err
);
    logic                             accept, first, final_w, short_pkt, mbz_nz;
    logic [IDX_W-1:0]                 idx;
    logic [HDR_WORDS-1:0][DATA_W-1:0] hw;
    word_t                            sum_next;
    hdr_t                             hdr;

    chx_seq u_seq (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_start(in_start),
        .in_last(in_last), .accept(accept), .first(first), .final_w(final_w),
        .idx(idx), .short_pkt(short_pkt)
    );

    chx_field_cap u_cap (
        .clk(clk), .rst(rst), .accept(accept), .first(first), .idx(idx),
        .word(in_word), .hw(hw)
    );

    chx_csum_acc u_acc (
        .clk(clk), .rst(rst), .accept(accept), .first(first), .word(in_word),
        .sum_next(sum_next)
    );

    assign hdr    = decode_hdr(hw);
    assign mbz_nz = first ? (in_word[BYTE_W-1:0] != '0) : (hdr.mbz != '0);

    chx_verdict u_verdict (
        .clk(clk), .rst(rst), .first(first), .final_w(final_w),
        .short_pkt(short_pkt), .mbz_nz(mbz_nz), .sum_next(sum_next),
        .done(pkt_done), .bad(bad_pkt), .err(csum_err)
    );

    assign opcode     = hdr.opcode;
    assign fwd_count  = hdr.fwd;
    assign pkt_size   = hdr.size;
    assign dst_addr   = hdr.dst_addr;
    assign dst_index  = hdr.dst_index;
    assign src_addr   = hdr.src_addr;
    assign src_index  = hdr.src_index;
    assign pkt_number = hdr.pkt_number;
    assign ack_number = hdr.ack_number;

    // R2
    mbz_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_start && in_last && in_word[7:0] != 8'h00) |=> bad_pkt);

    // R6
    one_word_done_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_start && in_last) |=> pkt_done);
endmodule

// File: tb/test_chaos_hdr_check.sv
module test_chaos_hdr_check;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, in_start, in_last;
    logic [15:0] in_word;
    logic [7:0]  opcode;
    logic [3:0]  fwd_count;
    logic [11:0] pkt_size;
    logic [15:0] dst_addr, dst_index, src_addr, src_index, pkt_number, ack_number;
    logic        pkt_done, bad_pkt, csum_err;

    int tests = 0;
    int fails = 0;
    logic [15:0] pkt [0:31];

    always #4 clk = ~clk;

    chaos_hdr_check i_chaos_hdr_check (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_start(in_start),
        .in_last(in_last), .in_word(in_word), .opcode(opcode),
        .fwd_count(fwd_count), .pkt_size(pkt_size), .dst_addr(dst_addr),
        .dst_index(dst_index), .src_addr(src_addr), .src_index(src_index),
        .pkt_number(pkt_number), .ack_number(ack_number), .pkt_done(pkt_done),
        .bad_pkt(bad_pkt), .csum_err(csum_err)
    );

    task automatic chk(input bit ok, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic put(input logic [15:0] w, input logic s, input logic l);
        @(negedge clk);
        in_valid = 1'b1; in_start = s; in_last = l; in_word = w;
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0; in_start = 1'b0; in_last = 1'b0; in_word = 16'hDEAD;
    endtask

    function automatic logic [15:0] fold_inv(input int n);
        logic [31:0] s = 0;
        for (int i = 0; i < n; i++) s += pkt[i];
        while (s > 32'hFFFF) s = (s & 32'hFFFF) + (s >> 16);
        return s[15:0] ^ 16'hFFFF;
    endfunction

    // fill n-1 data words from a seed and append the checksum word
    task automatic build(input int n, input logic [15:0] seed, input logic [7:0] mbz);
        for (int i = 0; i < n - 1; i++) pkt[i] = seed * 16'(i + 3) + 16'(i * 16'h1111);
        pkt[0][7:0] = mbz;
        pkt[n-1] = 16'h0;
        pkt[n-1] = fold_inv(n - 1);
    endtask

    function automatic logic [15:0] ef(input int n, input int k);
        return (k < n) ? pkt[k] : 16'h0;
    endfunction

    task automatic check_hdr(input int n, input string tag);
        chk(opcode == ef(n,0)[15:8], {tag, " R2 opcode"}, opcode, ef(n,0)[15:8]);
        chk({fwd_count, pkt_size} == ef(n,1), {tag, " R3 fwd/size"}, {fwd_count, pkt_size}, ef(n,1));
        chk(dst_addr == ef(n,2), {tag, " R4 dst_addr"}, dst_addr, ef(n,2));
        chk(dst_index == ef(n,3), {tag, " R4 dst_index"}, dst_index, ef(n,3));
        chk(src_addr == ef(n,4), {tag, " R4 src_addr"}, src_addr, ef(n,4));
        chk(src_index == ef(n,5), {tag, " R4 src_index"}, src_index, ef(n,5));
        chk(pkt_number == ef(n,6), {tag, " R4 pkt_number"}, pkt_number, ef(n,6));
        chk(ack_number == ef(n,7), {tag, " R4 ack_number"}, ack_number, ef(n,7));
    endtask

    task automatic check_done(input logic eb, input logic ee, input string tag);
        chk(pkt_done == 1'b1, {tag, " R7 done"}, pkt_done, 1);
        chk(bad_pkt == eb, {tag, " bad_pkt"}, bad_pkt, eb);
        chk(csum_err == ee, {tag, " R5 csum_err"}, csum_err, ee);
    endtask

    task automatic send(input int n);
        for (int i = 0; i < n; i++) put(pkt[i], i == 0, i == n - 1);
        idle();
    endtask

    task automatic t_reset();
        chk(pkt_done == 0 && bad_pkt == 0 && csum_err == 0, "R1 flags", {pkt_done, bad_pkt, csum_err}, 0);
        chk({opcode, fwd_count, pkt_size, dst_addr, ack_number} == 0, "R1 fields",
            {opcode, fwd_count, pkt_size}, 0);
    endtask

    task automatic t_good_long();
        build(12, 16'h0123, 8'h00);
        pkt[8] = 16'hFFFF; pkt[9] = 16'hFFFF; pkt[10] = 16'hFFFE;
        pkt[11] = 16'h0; pkt[11] = fold_inv(11);
        send(12);
        check_done(1'b0, 1'b0, "good R12");
        check_hdr(8, "good R12");
        idle();
        chk(pkt_done == 1'b0, "R7 done one cycle", pkt_done, 0);
    endtask

    task automatic t_bad_csum();
        build(9, 16'h3A07, 8'h00);
        pkt[8] = pkt[8] ^ 16'h0100;
        send(9);
        check_done(1'b0, 1'b1, "R5 corrupt");
    endtask

    task automatic t_mbz();
        build(9, 16'h5511, 8'h40);
        send(9);
        check_done(1'b1, 1'b0, "R2 mbz");
    endtask

    task automatic t_short();
        build(4, 16'h7721, 8'h00);
        send(4);
        check_done(1'b1, 1'b0, "R8 short");
        check_hdr(4, "R8 short");
        pkt[0] = 16'h8200;
        put(pkt[0], 1'b1, 1'b1);
        idle();
        check_done(1'b1, 1'b1, "R8 one-word");
        check_hdr(1, "R8 one-word");
    endtask

    task automatic t_back_to_back();
        logic [15:0] a [0:8];
        build(9, 16'h1F2E, 8'h00);
        for (int i = 0; i < 9; i++) a[i] = pkt[i];
        for (int i = 0; i < 9; i++) put(a[i], i == 0, i == 8);
        build(10, 16'h2C4D, 8'h03);
        put(pkt[0], 1'b1, 1'b0);
        check_done(1'b0, 1'b0, "R6 first of pair");
        for (int i = 1; i < 10; i++) put(pkt[i], 1'b0, i == 9);
        idle();
        check_done(1'b1, 1'b0, "R6 second of pair");
        check_hdr(10, "R6 second");
    endtask

    task automatic t_gaps_stray();
        build(10, 16'h0B0B, 8'h00);
        for (int i = 0; i < 10; i++) begin
            put(pkt[i], i == 0, i == 9);
            if (i == 3 || i == 8) begin idle(); idle(); end
        end
        idle();
        check_done(1'b0, 1'b0, "R10 gaps");
        check_hdr(10, "R10 gaps");
        put(16'hBEEF, 1'b0, 1'b0);
        put(16'hCAFE, 1'b0, 1'b1);
        idle();
        chk(pkt_done == 1'b0, "R10 stray done", pkt_done, 0);
        chk(bad_pkt == 1'b0 && csum_err == 1'b0, "R9 flags hold", {bad_pkt, csum_err}, 0);
        check_hdr(10, "R9 hold");
    endtask

    task automatic t_restart();
        build(9, 16'h6D6D, 8'h11);
        put(pkt[0], 1'b1, 1'b0); put(pkt[1], 1'b0, 1'b0); put(pkt[2], 1'b0, 1'b0);
        idle();
        chk(pkt_done == 1'b0, "R11 no done mid", pkt_done, 0);
        build(9, 16'h4242, 8'h00);
        send(9);
        check_done(1'b0, 1'b0, "R11 restart");
        check_hdr(9, "R11 restart");
    endtask

    task automatic t_flag_clear();
        build(9, 16'h1357, 8'hFF);
        pkt[8] = ~pkt[8];
        send(9);
        check_done(1'b1, 1'b1, "R9 prep");
        put(16'hA500, 1'b1, 1'b0);
        idle();
        chk(bad_pkt == 0 && csum_err == 0, "R9 start clears flags", {bad_pkt, csum_err}, 0);
        chk(dst_addr == 0 && opcode == 8'hA5, "R9 start clears fields", {opcode, dst_addr}, {8'hA5, 16'h0});
    endtask

    initial begin
        in_valid = 0; in_start = 0; in_last = 0; in_word = 0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        t_reset();
        t_good_long();
        t_bad_csum();
        t_mbz();
        t_short();
        t_back_to_back();
        t_gaps_stray();
        t_restart();
        t_flag_clear();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule